// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a purely combinational integer ALU of parameterised width, 32 bits by default. It is assembled from one repeated single-bit cell. Each cell holds a bitwise AND, a bitwise OR, a full adder with a controllable inverter on its B input, and a small output selector. A three-bit operation code picks one of five functions: AND, OR, add, subtract and set-on-less-than.

Subtraction inverts every B bit through the cell's inverter and feeds a carry of one into the lowest cell. Set-on-less-than reuses that subtract path. It takes the sign bit of the difference from the top cell and feeds it back into the lowest cell as the only result bit that can be set. Two flags sit beside the result. A zero flag detects an all-zero result and serves equality and inequality tests. An overflow flag applies a sign rule to the arithmetic functions. The block has no clock and holds no state.

Top module: `alu_slice`

## Requirements
- R1: Operation code 3'b100 drives the result with the bitwise AND of A and B.
- R2: Operation code 3'b101 drives the result with the bitwise OR of A and B.
- R3: Operation code 3'b110 drives the result with A + B modulo 2^N.
- R4: Operation code 3'b111 drives the result with A + ~B + 1 modulo 2^N, which equals A − B.
- R5: Operation code 3'b011 drives result bit 0 with bit N−1 of the wrapped difference A + ~B + 1, and drives result bits N−1..1 with 0. When the subtraction overflows, bit 0 therefore follows the wrapped sign and not the true order of A and B.
- R6: The zero flag is 1 exactly when every bit of the final result is 0, for every operation code including 3'b011.
- R7: For add, the overflow flag is 1 exactly when A and B have equal sign bits and the sum's sign bit differs from them.
- R8: For subtract and set-on-less-than, the overflow flag follows the rule in R7 with ~B in place of B.
- R9: For AND and OR, the overflow flag is 0.
- R10: The unused operation codes 3'b000, 3'b001 and 3'b010 give a result of 0, an overflow flag of 0 and a zero flag of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Function select {s, d0, d1} |
| opnd_a | input | N (32) | Operand A, two's complement |
| opnd_b | input | N (32) | Operand B, two's complement |
| result | output | N (32) | Selected function output |
| zero_flag | output | 1 | High when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow of the arithmetic path |

## Verification
Two checks can land on the same set of inputs. In one, set-on-less-than gives an all-zero result, so the zero flag rises. In the other, the same subtraction overflows, so the overflow flag rises alongside the compare output. The bench provokes this with operand pairs such as the most negative value against 1, where the wrapped difference is positive, bit 0 reads 0, and zero and overflow are both high. A reversed pair sets bit 0 while overflow is high. Each flag is judged separately against a bench model that computes the difference one bit wider and derives overflow from the two top bits, not from operand signs.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    OP_NONE0 = 3'b000,
    OP_NONE1 = 3'b001,
    OP_NONE2 = 3'b010,
    OP_SLT   = 3'b011,
    OP_AND   = 3'b100,
    OP_OR    = 3'b101,
    OP_ADD   = 3'b110,
    OP_SUB   = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    PICK_AND  = 3'd0,
    PICK_OR   = 3'd1,
    PICK_SUM  = 3'd2,
    PICK_LESS = 3'd3,
    PICK_NONE = 3'd4
  } cell_pick_e;

  typedef struct packed {
    logic       invert_b;   // XOR control on every B bit, also carry-in
    logic       arith;      // adder path feeds the overflow flag
    cell_pick_e pick;       // per-cell output selection
  } alu_ctrl_t;

  // Decode the three-bit code into cell controls.
  function automatic alu_ctrl_t decode_op(input logic [2:0] code);
    alu_ctrl_t c;
    c.invert_b = 1'b0;
    c.arith    = 1'b0;
    c.pick     = PICK_NONE;
    case (code)
      OP_AND: c.pick = PICK_AND;
      OP_OR:  c.pick = PICK_OR;
      OP_ADD: begin c.pick = PICK_SUM;  c.arith = 1'b1; end
      OP_SUB: begin c.pick = PICK_SUM;  c.arith = 1'b1; c.invert_b = 1'b1; end
      OP_SLT: begin c.pick = PICK_LESS; c.arith = 1'b1; c.invert_b = 1'b1; end
      default: c.pick = PICK_NONE;
    endcase
    return c;
  endfunction

  // Sign rule: equal operand signs and a differing sum sign.
  function automatic logic sign_overflow(input logic a_msb,
                                         input logic b_eff_msb,
                                         input logic sum_msb);
    return (a_msb == b_eff_msb) && (sum_msb != a_msb);
  endfunction

  // One-bit full adder pieces.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_slice_pkg::*;
(
  input  logic [2:0] op_code,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = decode_op(op_code);
  end

  // R8: compare must run on the inverting subtract path
  always_comb begin
    if (op_code == OP_SLT) begin
      p_slt_uses_sub_r8: assert (ctrl.invert_b && ctrl.arith);
    end
  end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_slice_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       invert_b,
  input  logic       carry_in,
  input  logic       less_in,
  input  cell_pick_e pick,
  output logic       res_bit,
  output logic       sum_bit,
  output logic       carry_out
);

  logic b_eff;
  logic and_bit;
  logic or_bit;
  logic logic_bit;

  assign b_eff     = b_bit ^ invert_b;
  assign and_bit   = a_bit & b_bit;
  assign or_bit    = a_bit | b_bit;
  assign sum_bit   = fa_sum(a_bit, b_eff, carry_in);
  assign carry_out = fa_carry(a_bit, b_eff, carry_in);

  // First selector: logical pair.
  assign logic_bit = (pick == PICK_OR) ? or_bit : and_bit;

  // Second selector in series: logical, sum, or fed-back compare.
  always_comb begin
    case (pick)
      PICK_AND, PICK_OR: res_bit = logic_bit;
      PICK_SUM:          res_bit = sum_bit;
      PICK_LESS:         res_bit = less_in;
      default:           res_bit = 1'b0;
    endcase
  end

  // R1 / R2: the cell output matches the chosen logic function
  always_comb begin
    if (pick == PICK_AND) begin
      p_cell_and_r1: assert (res_bit == (a_bit & b_bit));
    end
    if (pick == PICK_OR) begin
      p_cell_or_r2: assert (res_bit == (a_bit | b_bit));
    end
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);

  localparam int PAIRS = (WIDTH + 1) / 2;

  logic [PAIRS-1:0] pair_any;

  // First level of the OR tree over bit pairs.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    if (2 * p + 1 < WIDTH) begin : g_two
      assign pair_any[p] = value[2*p] | value[2*p+1];
    end else begin : g_one
      assign pair_any[p] = value[2*p];
    end
  end

  assign is_zero = ~|pair_any;

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t  ctrl;
  logic       carry [WIDTH+1];
  logic [MSB:0] sum_vec;
  logic       diff_sign;      // sign of the adder output, fed back for compare
  logic       b_eff_msb;
  logic       carry_into_msb;
  logic       carry_out_msb;
  logic       ovf_raw;

  alu_op_decode u_decode (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  assign carry[0] = ctrl.invert_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic less_i;
    if (i == 0) begin : g_lsb
      assign less_i = diff_sign;
    end else begin : g_upper
      assign less_i = 1'b0;
    end
    alu_bit_cell u_cell (
      .a_bit     (opnd_a[i]),
      .b_bit     (opnd_b[i]),
      .invert_b  (ctrl.invert_b),
      .carry_in  (carry[i]),
      .less_in   (less_i),
      .pick      (ctrl.pick),
      .res_bit   (result[i]),
      .sum_bit   (sum_vec[i]),
      .carry_out (carry[i+1])
    );
  end

  assign diff_sign      = sum_vec[MSB];
  assign b_eff_msb      = opnd_b[MSB] ^ ctrl.invert_b;
  assign carry_into_msb = carry[MSB];
  assign carry_out_msb  = carry[WIDTH];
  assign ovf_raw        = sign_overflow(opnd_a[MSB], b_eff_msb, diff_sign);
  assign ovf_flag       = ctrl.arith & ovf_raw;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value   (result),
    .is_zero (zero_flag)
  );

  always_comb begin
    // R7 / R8: sign rule agrees with the carry pair across the top cell
    if (ctrl.arith) begin
      p_ovf_carry_r7: assert (ovf_flag == (carry_into_msb ^ carry_out_msb));
    end
    // R9: logic functions never flag overflow
    if (op_code == OP_AND || op_code == OP_OR) begin
      p_no_ovf_logic_r9: assert (!ovf_flag);
    end
    // R3: ripple chain equals the native sum
    if (op_code == OP_ADD) begin
      p_add_value_r3: assert (result == opnd_a + opnd_b);
    end
    // R4 / R6: subtract gives zero exactly on equal operands
    if (op_code == OP_SUB) begin
      p_sub_value_r4: assert (result == opnd_a - opnd_b);
      p_sub_zero_r6: assert (zero_flag == (opnd_a == opnd_b));
    end
    // R5: compare clears every bit above bit 0
    if (op_code == OP_SLT) begin
      p_slt_upper_r5: assert (result[MSB:1] == '0);
    end
    // R10: unused codes produce nothing
    if (op_code[2] == 1'b0 && op_code != OP_SLT) begin
      p_unused_r10: assert (zero_flag && !ovf_flag);
    end
  end

endmodule

// File: tb/alu_slice_test.sv
module alu_slice_test;

  localparam int W = 32;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         z;
    logic         v;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'b100, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0},
    '{3'b101, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1'b0, 1'b0},
    '{3'b100, 32'h1234_5678, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    '{3'b101, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0},
    '{3'b110, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1},
    '{3'b110, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1},
    '{3'b110, 32'h0000_0005, 32'hFFFF_FFFB, 32'h0000_0000, 1'b1, 1'b0},
    '{3'b111, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0},
    '{3'b111, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1},
    '{3'b111, 32'h0000_0003, 32'h0000_0007, 32'hFFFF_FFFC, 1'b0, 1'b0},
    '{3'b011, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0},
    '{3'b011, 32'h0000_0002, 32'h0000_0002, 32'h0000_0000, 1'b1, 1'b0},
    '{3'b011, 32'h0000_0003, 32'h0000_0007, 32'h0000_0001, 1'b0, 1'b0},
    '{3'b011, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1},
    '{3'b011, 32'h0000_0001, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1},
    '{3'b000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0},
    '{3'b010, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_code = 3'b000;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] result;
  logic         zero_flag;
  logic         ovf_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu_slice #(.WIDTH(W)) uut (
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
  );

  function automatic string tag_for(input logic [2:0] op);
    case (op)
      3'b100: return "R1";
      3'b101: return "R2";
      3'b110: return "R3";
      3'b111: return "R4";
      3'b011: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string vtag_for(input logic [2:0] op);
    case (op)
      3'b110: return "R7";
      3'b111, 3'b011: return "R8";
      3'b100, 3'b101: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Independent model: one extra bit of width, overflow from top two bits.
  task automatic model(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, output logic [W-1:0] r,
                       output logic z, output logic v);
    logic signed [W:0] wide;
    r = '0;
    v = 1'b0;
    wide = '0;
    case (op)
      3'b100: r = a & b;
      3'b101: r = a | b;
      3'b110: begin
        wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
        r = wide[W-1:0];
        v = wide[W] ^ wide[W-1];
      end
      3'b111, 3'b011: begin
        wide = $signed({a[W-1], a}) - $signed({b[W-1], b});
        v = wide[W] ^ wide[W-1];
        if (op == 3'b111) r = wide[W-1:0];
        else r = {{(W-1){1'b0}}, wide[W-1]};
      end
      default: r = '0;
    endcase
    z = (r == '0);
  endtask

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [2:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic [W-1:0] er,
                                 input logic ez, input logic ev);
    @(posedge clk);
    op_code = op;
    opnd_a  = a;
    opnd_b  = b;
    @(negedge clk);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result op=%03b a=%h b=%h: actual %h expected %h",
               tag_for(op), op, a, b, result, er);
    end
    check_bit("R6", "zero flag", zero_flag, ez);
    check_bit(vtag_for(op), "overflow flag", ovf_flag, ev);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [W-1:0] er;
    logic ez;
    logic ev;
    logic [W-1:0] seed;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state after bench reset: code 000 with zero operands (R10)
    checks++;
    if (result !== '0) begin
      errors++;
      $display("FAIL R10 idle result: actual %h expected 0", result);
    end
    check_bit("R6", "idle zero flag", zero_flag, 1'b1);
    check_bit("R10", "idle overflow flag", ovf_flag, 1'b0);

    // Table of hand-computed vectors, incl. compare with overflow (R5, R8)
    for (int k = 0; k < NV; k++) begin
      apply_and_check(VECS[k].op, VECS[k].a, VECS[k].b,
                      VECS[k].res, VECS[k].z, VECS[k].v);
    end

    // Directed corners: unused code 001 (R10), subtract of the most
    // negative value (R8), compare of equal negatives (R5, R6).
    apply_and_check(3'b001, 32'hDEAD_BEEF, 32'h0000_0001, '0, 1'b1, 1'b0);
    apply_and_check(3'b111, 32'h0000_0000, 32'h8000_0000,
                    32'h8000_0000, 1'b0, 1'b1);
    apply_and_check(3'b011, 32'h8000_0000, 32'h8000_0000, '0, 1'b1, 1'b0);
    apply_and_check(3'b110, 32'hFFFF_FFFF, 32'h0000_0001, '0, 1'b1, 1'b0);

    // Pseudo-random sweep over every code against the bench model (R1..R10)
    seed = 32'h1F2E_3D4C;
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      rb = (n % 5 == 0) ? ra : seed;
      model(3'(n % 8), ra, rb, er, ez, ev);
      apply_and_check(3'(n % 8), ra, rb, er, ez, ev);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule